// File: doc/BRIEF.md
# Prescaled Wrapping Timer Counter

This block is a free-running timer/counter steered by one 16-bit control word. A power-of-two prescaler divides the raw clock into count ticks. The counter advances up or down on each tick, and its width can be set to the narrow, middle or wide setting (8, 16 or 32 bits by default). A wrap past the top of the selected width raises a one-clock overflow pulse. A wrap below zero raises a one-clock underflow pulse.

A re-trigger input reloads the counter. The reload value is zero when counting up and the top of the width when counting down. A field in the control word sets when the reload lands: on the next raw clock, on the next prescaled tick, or on the next raw clock with the prescaler count cleared at the same time. Enabling and disabling pass through a short synchronizer, and a busy flag covers that interval. A soft-reset bit clears the block in one write. An auto-lock option records reloads and wraps in a sticky flag that stays set until it is cleared.

Top module: `wrap_timer`

## Requirements
- R1: After reset, the control readback, count, overflow, underflow, lock flag, busy and running outputs are all zero.
- R2: Control bits [8:6] select the prescaler. Codes 0..7 advance the counter once every 1, 2, 4, 8, 16, 64, 256 or 1024 raw clocks while running.
- R3: Control bits [3:2] select the width. Code 1 is the narrow width, code 2 is the wide width, and codes 0 and 3 are the middle width. Counting wraps at the top of the selected width.
- R4: A write with bit 0 set clears the control word, count, prescaler, flags and enable at that clock, whatever the other written bits are. A write with bit 0 clear acts as a plain control write, and bit 0 always reads back 0.
- R5: Bit 1 (enable) reads back in the cycle after the write. The busy output is high for exactly two cycles after a write that changes the enable, and running changes when busy falls.
- R6: With sync field bits [5:4] at code 0, or at reserved code 3, a re-trigger reloads the counter on the next raw clock. The reload value is 0 when counting up and the width top when counting down.
- R7: With sync code 1, a re-trigger is held pending and the reload lands on the next prescaled tick.
- R8: With sync code 2, the reload lands on the next raw clock, and the prescaler count restarts from zero at that same clock.
- R9: Counting up from the width top to zero raises overflow for one clock.
- R10: Counting down from zero to the width top raises underflow for one clock.
- R11: When bit 9 (auto-lock) is set, every overflow, underflow or applied reload sets the lock flag. When it is clear, the flag is left untouched. The lock_clr input clears the flag, and a setting event in the same cycle wins over the clear.
- R12: While running is low, the count holds, and re-triggers and ticks have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| dir_down | input | 1 | 1 counts down, 0 counts up |
| retrig | input | 1 | Re-trigger (reload) request |
| lock_clr | input | 1 | Clears the lock flag |
| ctl_rdata | output | 16 | Control word readback |
| en_busy | output | 1 | Enable change in flight |
| running | output | 1 | Synchronized enable in force |
| count | output | W_WIDE | Counter value |
| ovf | output | 1 | Overflow pulse |
| unf | output | 1 | Underflow pulse |
| lock_upd | output | 1 | Sticky lock-update flag |

## Verification
The bench builds the block with its default parameters: widths 8/16/32, two synchronizer stages and a 10-bit prescaler. The wide width cannot be wrapped by counting alone in a short run. The bench reaches its top instead by a down-direction reload followed by a switch to up counting, and the middle width and the reserved width code are handled the same way. The narrow width is short enough for natural overflow and underflow within a few hundred clocks. The full 10-bit prescaler range lets every divide code, including 1024, run through several ticks.

// File: rtl/wrap_timer_pkg.sv
package wrap_timer_pkg;

   localparam int CTL_W = 16;

   // bit positions inside the control word
   localparam int B_SWRST = 0;
   localparam int B_EN    = 1;
   localparam int B_ALOCK = 9;

   // bits that hold state; bit 0 is write-only
   localparam logic [CTL_W-1:0] CTL_KEEP = 16'h03FE;

   typedef enum logic [1:0] {
      WIDTH_MID    = 2'd0,
      WIDTH_NARROW = 2'd1,
      WIDTH_WIDE   = 2'd2,
      WIDTH_RSVD   = 2'd3
   } width_e;

   typedef enum logic [1:0] {
      RL_RAW     = 2'd0,
      RL_TICK    = 2'd1,
      RL_RAW_CLR = 2'd2,
      RL_RSVD    = 2'd3
   } reload_e;

   typedef struct packed {
      logic [5:0] spare;
      logic       alock;
      logic [2:0] psc;
      reload_e    sync;
      width_e     mode;
      logic       en;
      logic       swrst;
   } ctl_t;

   // log2 of the divide ratio for each prescaler code
   function automatic int unsigned psc_shift(input logic [2:0] code);
      case (code)
         3'd5:    return 6;
         3'd6:    return 8;
         3'd7:    return 10;
         default: return int'(code);
      endcase
   endfunction

endpackage

// File: rtl/wrap_timer_ctl.sv
module wrap_timer_ctl
   import wrap_timer_pkg::*;
#(
   parameter int SYNC_STAGES = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wr_data,
   output ctl_t             ctl_q,
   output logic             soft_clr,
   output logic             run,
   output logic             busy
);

   logic [SYNC_STAGES-1:0] stg;

   // R4: soft reset wins over every other field of the same write
   assign soft_clr = wr_en && wr_data[B_SWRST];

   always_ff @(posedge clk) begin
      if (!rst_n || soft_clr)
         ctl_q <= '0;
      else if (wr_en)
         ctl_q <= ctl_t'(wr_data & CTL_KEEP);
   end

   // R5: enable passes a shift chain; busy covers every stage still differing
   always_ff @(posedge clk) begin
      if (!rst_n || soft_clr)
         stg <= '0;
      else
         stg <= {stg[SYNC_STAGES-2:0], ctl_q.en};
   end

   always_comb begin
      busy = (stg[0] != ctl_q.en);
      for (int i = 1; i < SYNC_STAGES; i++)
         busy = busy | (stg[i] != stg[i-1]);
   end

   assign run = stg[SYNC_STAGES-1];

endmodule

// File: rtl/wrap_timer_presc.sv
module wrap_timer_presc
   import wrap_timer_pkg::*;
#(
   parameter int PS_W = 10
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       run,
   input  logic [2:0] code,
   input  logic       zap,
   output logic       tick
);

   logic [PS_W-1:0] pc;
   logic [PS_W-1:0] limit;

   // R2: terminal count is ratio minus one
   assign limit = PS_W'((32'd1 << psc_shift(code)) - 32'd1);
   assign tick  = run && (pc == limit);

   // R8: zap restarts the division at a reload
   always_ff @(posedge clk) begin
      if (!rst_n || clr || !run || zap || tick)
         pc <= '0;
      else
         pc <= pc + 1'b1;
   end

endmodule

// File: rtl/wrap_timer_cnt.sv
module wrap_timer_cnt
   import wrap_timer_pkg::*;
#(
   parameter int W_NARROW = 8,
   parameter int W_MID    = 16,
   parameter int W_WIDE   = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              run,
   input  logic              tick,
   input  logic              dir_down,
   input  logic              retrig,
   input  logic              lock_clr,
   input  logic              alock,
   input  width_e            mode,
   input  reload_e           sync,
   output logic [W_WIDE-1:0] count,
   output logic              ovf,
   output logic              unf,
   output logic              lock_upd,
   output logic              zap
);

   localparam logic [W_WIDE-1:0] TOP_N = {{(W_WIDE-W_NARROW){1'b0}}, {W_NARROW{1'b1}}};
   localparam logic [W_WIDE-1:0] TOP_M = {{(W_WIDE-W_MID){1'b0}}, {W_MID{1'b1}}};
   localparam logic [W_WIDE-1:0] TOP_W = {W_WIDE{1'b1}};

   logic [W_WIDE-1:0] top, cur, nxt;
   reload_e           sync_eff;
   logic              pend, req, apply, wrap_up, wrap_dn, lock_set;

   // R3: reserved width code falls back to the middle width
   always_comb begin
      case (mode)
         WIDTH_NARROW: top = TOP_N;
         WIDTH_WIDE:   top = TOP_W;
         default:      top = TOP_M;
      endcase
   end

   // R6: reserved sync code behaves as the raw-clock setting
   assign sync_eff = (sync == RL_RSVD) ? RL_RAW : sync;
   assign req      = run && (retrig || pend);
   // R7: tick-aligned reload waits for the tick
   assign apply    = req && ((sync_eff != RL_TICK) || tick);
   assign zap      = apply && (sync_eff == RL_RAW_CLR);

   assign cur     = count & top;
   assign wrap_up = run && tick && !apply && !dir_down && (cur == top);
   assign wrap_dn = run && tick && !apply &&  dir_down && (cur == '0);

   always_comb begin
      if (apply)
         nxt = dir_down ? top : '0;
      else if (!tick)
         nxt = count;
      else if (dir_down)
         nxt = (cur == '0) ? top : cur - 1'b1;
      else
         nxt = (cur == top) ? '0 : cur + 1'b1;
   end

   // R11: sticky flag fed by wraps and reloads
   assign lock_set = alock && (apply || wrap_up || wrap_dn);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         count    <= '0;
         pend     <= 1'b0;
         ovf      <= 1'b0;
         unf      <= 1'b0;
         lock_upd <= 1'b0;
      end else begin
         if (run)
            count <= nxt;                 // R12: hold while stopped
         pend <= req && !apply;
         ovf  <= wrap_up;                 // R9
         unf  <= wrap_dn;                 // R10
         if (lock_set)
            lock_upd <= 1'b1;
         else if (lock_clr)
            lock_upd <= 1'b0;
      end
   end

endmodule

// File: rtl/wrap_timer.sv
module wrap_timer
   import wrap_timer_pkg::*;
#(
   parameter int W_NARROW    = 8,
   parameter int W_MID       = 16,
   parameter int W_WIDE      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int PS_W        = 10
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [CTL_W-1:0]  ctl_wdata,
   input  logic              dir_down,
   input  logic              retrig,
   input  logic              lock_clr,
   output logic [CTL_W-1:0]  ctl_rdata,
   output logic              en_busy,
   output logic              running,
   output logic [W_WIDE-1:0] count,
   output logic              ovf,
   output logic              unf,
   output logic              lock_upd
);

   generate
      if (!(W_NARROW > 0 && W_NARROW < W_MID && W_MID < W_WIDE)) begin : g_bad_width
         $error("wrap_timer: widths must rise strictly, narrow < mid < wide");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("wrap_timer: SYNC_STAGES must be at least 2");
      end
      if (PS_W < 10) begin : g_bad_psc
         $error("wrap_timer: PS_W must hold the largest divide ratio");
      end
   endgenerate

   ctl_t ctl_q;
   logic soft_clr, run, tick, zap;

   wrap_timer_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ctl_we),
      .wr_data  (ctl_wdata),
      .ctl_q    (ctl_q),
      .soft_clr (soft_clr),
      .run      (run),
      .busy     (en_busy)
   );

   wrap_timer_presc #(.PS_W(PS_W)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_clr),
      .run   (run),
      .code  (ctl_q.psc),
      .zap   (zap),
      .tick  (tick)
   );

   wrap_timer_cnt #(.W_NARROW(W_NARROW), .W_MID(W_MID), .W_WIDE(W_WIDE)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (soft_clr),
      .run      (run),
      .tick     (tick),
      .dir_down (dir_down),
      .retrig   (retrig),
      .lock_clr (lock_clr),
      .alock    (ctl_q.alock),
      .mode     (ctl_q.mode),
      .sync     (ctl_q.sync),
      .count    (count),
      .ovf      (ovf),
      .unf      (unf),
      .lock_upd (lock_upd),
      .zap      (zap)
   );

   assign ctl_rdata = ctl_q;
   assign running   = run;

endmodule

// File: rtl/wrap_timer_chk.sv
module wrap_timer_chk #(
   parameter int W_NARROW = 8,
   parameter int W_MID    = 16,
   parameter int W_WIDE   = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_we,
   input logic [15:0]       ctl_wdata,
   input logic [15:0]       ctl_rdata,
   input logic              en_busy,
   input logic              running,
   input logic [W_WIDE-1:0] count,
   input logic              ovf,
   input logic              unf,
   input logic              lock_upd
);

   logic [W_WIDE-1:0] top_now;
   always_comb begin
      case (ctl_rdata[3:2])
         2'd1:    top_now = {{(W_WIDE-W_NARROW){1'b0}}, {W_NARROW{1'b1}}};
         2'd2:    top_now = {W_WIDE{1'b1}};
         default: top_now = {{(W_WIDE-W_MID){1'b0}}, {W_MID{1'b1}}};
      endcase
   end

   AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we && ctl_wdata[0] |=> (ctl_rdata == '0) && !running && !en_busy && (count == '0)); // R4

   AST_RUN_CHANGE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (running != $past(running)) && !$past(ctl_we && ctl_wdata[0]) |-> $past(en_busy)); // R5

   AST_OVF_LANDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> (count == '0)); // R9

   AST_UNF_LANDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      unf && $stable(ctl_rdata[3:2]) |-> (count == top_now)); // R10

   AST_NO_DOUBLE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf && unf)); // R9

   AST_LOCK_NEEDS_ALOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_upd) |-> $past(ctl_rdata[9])); // R11

   AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(running) && !$past(ctl_we && ctl_wdata[0]) |-> $stable(count)); // R12

endmodule

bind wrap_timer wrap_timer_chk #(.W_NARROW(W_NARROW), .W_MID(W_MID), .W_WIDE(W_WIDE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_we    (ctl_we),
   .ctl_wdata (ctl_wdata),
   .ctl_rdata (ctl_rdata),
   .en_busy   (en_busy),
   .running   (running),
   .count     (count),
   .ovf       (ovf),
   .unf       (unf),
   .lock_upd  (lock_upd)
);

// File: tb/sim_wrap_timer.sv
`timescale 1ns/1ps
module sim_wrap_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic        dir_down = 1'b0;
   logic        retrig = 1'b0;
   logic        lock_clr = 1'b0;
   logic [15:0] ctl_rdata;
   logic        en_busy, running, ovf, unf, lock_upd;
   logic [31:0] count;

   always #2.5 clk = ~clk;   // 200 MHz

   wrap_timer u0 (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .dir_down(dir_down), .retrig(retrig), .lock_clr(lock_clr),
      .ctl_rdata(ctl_rdata), .en_busy(en_busy), .running(running),
      .count(count), .ovf(ovf), .unf(unf), .lock_upd(lock_upd)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   int    cyc = 0;
   bit    done = 0;
   string phase = "R1 reset";
   int    ovf_seen = 0;

   // ---------------- behavioural reference model ----------------
   logic [15:0] m_ctl;
   bit          m_s1, m_s2, m_pend, m_ovf, m_unf, m_lock;
   int          m_pc;
   logic [31:0] m_cnt;

   function automatic int ratio_of(input logic [2:0] c);
      int r [8] = '{1, 2, 4, 8, 16, 64, 256, 1024};
      return r[c];
   endfunction

   function automatic logic [31:0] top_of(input logic [1:0] m);
      if (m == 2'd1) return 32'h0000_00FF;
      if (m == 2'd2) return 32'hFFFF_FFFF;
      return 32'h0000_FFFF;
   endfunction

   always @(posedge clk) begin
      bit run, tick, req, app, n_ovf, n_unf, n_lock;
      int sy, n_pc;
      logic [31:0] tp, cur, n_cnt;
      if (!rst_n) begin
         m_ctl = '0; m_s1 = 0; m_s2 = 0; m_pend = 0; m_ovf = 0; m_unf = 0;
         m_lock = 0; m_pc = 0; m_cnt = '0;
      end else begin
         run  = m_s2;
         tick = run && (m_pc == ratio_of(m_ctl[8:6]) - 1);
         sy   = int'(m_ctl[5:4]);
         if (sy == 3) sy = 0;
         tp   = top_of(m_ctl[3:2]);
         req  = run && (retrig || m_pend);
         app  = req && (sy != 1 || tick);
         n_ovf = 0; n_unf = 0; n_cnt = m_cnt;
         if (run) begin
            if (app) n_cnt = dir_down ? tp : 32'd0;
            else if (tick) begin
               cur = m_cnt & tp;
               if (!dir_down) begin
                  if (cur == tp) begin n_cnt = 0; n_ovf = 1; end else n_cnt = cur + 1;
               end else begin
                  if (cur == 0) begin n_cnt = tp; n_unf = 1; end else n_cnt = cur - 1;
               end
            end
         end
         n_pc = (!run || tick || (app && sy == 2)) ? 0 : (m_pc + 1) % 1024;
         if (m_ctl[9] && (app || n_ovf || n_unf)) n_lock = 1;
         else if (lock_clr) n_lock = 0;
         else n_lock = m_lock;
         m_pend = req && !app;
         m_s2 = m_s1;
         m_s1 = m_ctl[1];
         if (ctl_we) m_ctl = ctl_wdata & 16'h03FE;
         m_cnt = n_cnt; m_pc = n_pc; m_ovf = n_ovf; m_unf = n_unf; m_lock = n_lock;
         if (ctl_we && ctl_wdata[0]) begin
            m_ctl = '0; m_s1 = 0; m_s2 = 0; m_pend = 0; m_ovf = 0; m_unf = 0;
            m_lock = 0; m_pc = 0; m_cnt = '0;
         end
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("ctl_rdata", 32'(ctl_rdata), 32'(m_ctl));
         chk("en_busy", 32'(en_busy), 32'((m_ctl[1] != m_s1) || (m_s1 != m_s2)));
         chk("running", 32'(running), 32'(m_s2));
         chk("count", count, m_cnt);
         chk("ovf", 32'(ovf), 32'(m_ovf));
         chk("unf", 32'(unf), 32'(m_unf));
         chk("lock_upd", 32'(lock_upd), 32'(m_lock));
         if (ovf) ovf_seen++;
      end
   end

   task automatic summary();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
      end
   end

   function automatic logic [15:0] cfg(input int mode, input int sy, input int psc,
                                       input bit al, input bit en);
      return {6'd0, al, 3'(psc), 2'(sy), 2'(mode), en, 1'b0};
   endfunction

   task automatic idle(input int n); repeat (n) @(negedge clk); endtask

   task automatic wr(input logic [15:0] d);
      @(negedge clk); ctl_we = 1; ctl_wdata = d;
      @(negedge clk); ctl_we = 0; ctl_wdata = '0;
   endtask

   task automatic kick();
      @(negedge clk); retrig = 1;
      @(negedge clk); retrig = 0;
   endtask

   task automatic start(input logic [15:0] d);
      wr(16'h0001);
      wr(d);
      idle(2);
   endtask

   // up-wrap of a wide counter reached through a down reload
   task automatic wide_wrap(input int mode, input logic [31:0] top);
      dir_down = 1;
      start(cfg(mode, 0, 0, 0, 1));
      idle(3);
      kick();
      chk("reload to top R6", count, top);
      dir_down = 0;
      idle(3);
   endtask

   initial begin
      idle(4);
      rst_n = 1;
      @(negedge clk);
      phase = "R1 reset";
      chk("rdata R1", 32'(ctl_rdata), 0); chk("count R1", count, 0);
      chk("busy R1", 32'(en_busy), 0);    chk("running R1", 32'(running), 0);
      chk("ovf R1", 32'(ovf), 0);         chk("lock R1", 32'(lock_upd), 0);

      phase = "R5 enable handshake";
      wr(cfg(1, 0, 0, 0, 1));
      chk("enable readback R5", 32'(ctl_rdata[1]), 1);
      chk("busy cycle1 R5", 32'(en_busy), 1);
      idle(1); chk("busy cycle2 R5", 32'(en_busy), 1);
      chk("still stopped R5", 32'(running), 0);
      idle(1); chk("busy done R5", 32'(en_busy), 0);
      chk("running R5", 32'(running), 1);

      phase = "R9 R3 narrow overflow";
      ovf_seen = 0;
      idle(300);
      chk("one overflow R9", 32'(ovf_seen), 1);

      phase = "R12 stopped hold";
      wr(cfg(1, 0, 0, 0, 0));
      idle(4);
      kick();
      idle(10);
      chk("stopped R12", 32'(running), 0);

      for (int c = 0; c < 8; c++) begin
         phase = $sformatf("R2 prescaler code %0d", c);
         start(cfg(0, 0, c, 0, 1));
         idle(3 * ratio_of(3'(c)) + 8);
      end

      phase = "R10 narrow underflow";
      dir_down = 1;
      start(cfg(1, 0, 1, 0, 1));
      idle(600);
      dir_down = 0;

      phase = "R3 middle width";      wide_wrap(0, 32'h0000_FFFF);
      phase = "R3 reserved width";    wide_wrap(3, 32'h0000_FFFF);
      phase = "R3 wide width";        wide_wrap(2, 32'hFFFF_FFFF);

      phase = "R6 reserved sync";
      start(cfg(1, 3, 0, 0, 1));
      idle(20); kick(); chk("sync3 reload R6", count, 0);
      idle(5);

      phase = "R7 tick-aligned reload";
      start(cfg(0, 1, 4, 0, 1));
      idle(40); kick(); idle(40);
      idle(7);  kick(); idle(40);

      phase = "R8 reload clears prescaler";
      start(cfg(0, 2, 4, 0, 1));
      idle(43); kick(); idle(60);

      phase = "R11 auto-lock";
      start(cfg(1, 0, 0, 1, 1));
      idle(5); kick();
      chk("lock set on reload R11", 32'(lock_upd), 1);
      @(negedge clk); lock_clr = 1; @(negedge clk); lock_clr = 0;
      chk("lock cleared R11", 32'(lock_upd), 0);
      wr(cfg(1, 0, 0, 0, 1));
      kick(); idle(300);
      chk("lock untouched when off R11", 32'(lock_upd), 0);
      wr(cfg(1, 0, 0, 1, 1));
      idle(300);
      chk("lock set on overflow R11", 32'(lock_upd), 1);

      phase = "R4 soft reset";
      wr(16'hFFFF);
      chk("rdata cleared R4", 32'(ctl_rdata), 0);
      chk("count cleared R4", count, 0);
      chk("lock cleared R4", 32'(lock_upd), 0);
      chk("stopped R4", 32'(running), 0);
      wr(cfg(2, 0, 0, 0, 1));
      idle(30);
      wr(cfg(2, 0, 0, 0, 1));
      chk("bit0 clear keeps count R4", 32'(count != 0), 1);
      chk("bit0 reads 0 R4", 32'(ctl_rdata[0]), 0);
      idle(10);

      summary();
   end

endmodule